// File: doc/BRIEF.md
# Binomial Pseudo-Random Noise Generator

This block supplies a bank of signed noise words, one per neuron of a stochastically settling network. Each channel runs its own maximal-length shift register. On every enabled cycle the register moves on by as many steps as the channel has noise bits, so every sample is built from fresh bits. The channel counts the ones among those bits and subtracts half the bit count, which gives a centred binomial value that approximates a zero-mean gaussian.

The centred count is multiplied by an unsigned temperature code and then shifted right arithmetically. The spread of every channel therefore follows the temperature that an external annealing controller steps down over time. A temperature of zero gives exactly zero on every channel, which is the deterministic mean-field case. Channels are decorrelated by deriving a distinct seed for each one from a shared base seed. The controller can reload that base seed at any time.

Top module: `bnoise_gen`

## Requirements
- R1: The block has 32 channels. Channel c drives the signed 8-bit field `noise_o[c*8 +: 8]` in two's complement.
- R2: While `rst` is high at a rising edge, every output field becomes zero and every channel register loads the seed derived from the default base 0x5EED1234, using the rule in R7.
- R3: Each channel register is 32 bits wide. One step shifts it left by one bit and inserts s[31]^s[21]^s[1]^s[0] at bit 0. Each enabled cycle applies 16 steps.
- R4: On a rising edge with `en_i` high and `seed_load_i` low, a channel output becomes ((ones in register bits [15:0]) - 8) * `temp_i`, arithmetically shifted right by 1. The register value used is the one held before that edge's advance.
- R5: A temperature code of 0 on an enabled cycle makes every output exactly zero on the next cycle.
- R6: With `en_i` and `seed_load_i` both low, the outputs and the channel registers keep their values.
- R7: With `seed_load_i` high, channel c loads `seed_i` XOR ((0x9E3779B9*(c+1)) mod 2^32), with a zero result replaced by 1. The outputs do not change on that edge, and the load takes priority over `en_i`.
- R8: No channel register is ever all zero.
- R9: Over many samples the mean output is near zero, and the standard deviation scales in proportion to the temperature code.
- R10: Two different channels show a sample correlation close to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance registers and update the noise words |
| seed_load_i | input | 1 | Load per-channel seeds derived from `seed_i` |
| seed_i | input | 32 | Base seed |
| temp_i | input | 4 | Temperature code that scales the spread |
| noise_o | output | 256 | 32 signed 8-bit noise words |

## Verification
The bench runs a behavioural model of the registers and the scaling on every cycle. A wrong tap, a step count off by one, or a sample taken after the advance rather than before it makes every later word differ. It loads a base seed chosen so that one channel's derived seed is zero. A design that missed the substitution would lock that channel at a constant output forever. It also checks temperature zero, enable held low, and a load arriving together with enable: a design that let the load update the outputs, or that ignored the priority, would show a mismatch on the very next word. Statistical checks of the mean, of the ratio of spreads between two temperatures, and of the correlation between two channels catch a centring error, a shift in the wrong direction, and channels left in step with each other.

// File: rtl/bnoise_pkg.sv
package bnoise_pkg;
   localparam int          LFSR_W     = 32;
   localparam logic [31:0] LFSR_TAPS  = 32'h8020_0003;  // bits 31,21,1,0
   localparam logic [31:0] SEED_MULT  = 32'h9E37_79B9;

   // per-channel seed: distinct odd-multiple mix, never all-zero
   function automatic logic [LFSR_W-1:0] chan_seed(input logic [LFSR_W-1:0] base,
                                                  input int unsigned idx);
      logic [LFSR_W-1:0] mixed;
      mixed = base ^ (SEED_MULT * 32'(idx + 1));
      return (mixed == '0) ? LFSR_W'(1) : mixed;
   endfunction
endpackage

// File: rtl/bnoise_lfsr.sv
module bnoise_lfsr
   import bnoise_pkg::*;
#(
   parameter int          CH_IDX       = 0,
   parameter int          STEPS        = 16,
   parameter logic [31:0] DEFAULT_SEED = 32'h5EED_1234
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              adv,
   input  logic [LFSR_W-1:0] base_seed,
   output logic [LFSR_W-1:0] state_o
);
   logic [LFSR_W-1:0] st_q;
   logic [LFSR_W-1:0] st_nxt;

   always_comb begin
      st_nxt = st_q;
      for (int k = 0; k < STEPS; k++)
         st_nxt = {st_nxt[LFSR_W-2:0], ^(st_nxt & LFSR_TAPS)};
   end

   always_ff @(posedge clk) begin
      if (rst)       st_q <= chan_seed(DEFAULT_SEED, CH_IDX);
      else if (load) st_q <= chan_seed(base_seed, CH_IDX);
      else if (adv)  st_q <= st_nxt;
   end

   assign state_o = st_q;
endmodule

// File: rtl/bnoise_scale.sv
module bnoise_scale #(
   parameter int BITS   = 16,
   parameter int TEMP_W = 4,
   parameter int SHIFT  = 1,
   parameter int OUT_W  = 8
) (
   input  logic [BITS-1:0]          bits_i,
   input  logic [TEMP_W-1:0]        temp_i,
   output logic signed [OUT_W-1:0]  val_o
);
   localparam int CNT_W  = $clog2(BITS + 1);
   localparam int CEN_W  = CNT_W + 1;
   localparam int PROD_W = CEN_W + TEMP_W + 1;
   localparam logic signed [CEN_W-1:0] HALF_S = CEN_W'(BITS / 2);

   logic [CNT_W-1:0]         cnt;
   logic signed [CEN_W-1:0]  cen;
   logic signed [PROD_W-1:0] prod;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < BITS; i++)
         cnt = cnt + CNT_W'(bits_i[i]);
   end

   assign cen  = $signed({1'b0, cnt}) - HALF_S;
   assign prod = cen * $signed({1'b0, temp_i});

   generate
      if (SHIFT == 0) begin : g_noshift
         assign val_o = OUT_W'(prod);
      end else begin : g_shift
         logic signed [PROD_W-1:0] shifted;
         assign shifted = prod >>> SHIFT;
         assign val_o   = OUT_W'(shifted);
      end
   endgenerate
endmodule

// File: rtl/bnoise_gen.sv
module bnoise_gen
   import bnoise_pkg::*;
#(
   parameter int          NUM_CH       = 32,
   parameter int          BITS_PER_CH  = 16,
   parameter int          TEMP_W       = 4,
   parameter int          SHIFT        = 1,
   parameter int          OUT_W        = 8,
   parameter logic [31:0] DEFAULT_SEED = 32'h5EED_1234
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en_i,
   input  logic                    seed_load_i,
   input  logic [LFSR_W-1:0]       seed_i,
   input  logic [TEMP_W-1:0]       temp_i,
   output logic [NUM_CH*OUT_W-1:0] noise_o
);
   localparam int MAX_MAG = ((BITS_PER_CH / 2) * ((1 << TEMP_W) - 1)) >>> SHIFT;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("bnoise_gen: NUM_CH must be at least 1");
      end
      if (BITS_PER_CH < 2 || (BITS_PER_CH % 2) != 0 || BITS_PER_CH > LFSR_W) begin : g_bad_bits
         $error("bnoise_gen: BITS_PER_CH must be even, >= 2 and <= register width");
      end
      if ((1 << (OUT_W - 1)) <= MAX_MAG) begin : g_bad_out
         $error("bnoise_gen: OUT_W too narrow for the scaled range");
      end
   endgenerate

   logic                    adv;
   logic [NUM_CH*LFSR_W-1:0] lfsr_flat;

   assign adv = en_i & ~seed_load_i;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [LFSR_W-1:0]       st;
         logic signed [OUT_W-1:0] scaled;
         logic signed [OUT_W-1:0] noise_q;

         bnoise_lfsr #(
            .CH_IDX       (c),
            .STEPS        (BITS_PER_CH),
            .DEFAULT_SEED (DEFAULT_SEED)
         ) u_lfsr (
            .clk       (clk),
            .rst       (rst),
            .load      (seed_load_i),
            .adv       (adv),
            .base_seed (seed_i),
            .state_o   (st)
         );

         bnoise_scale #(
            .BITS   (BITS_PER_CH),
            .TEMP_W (TEMP_W),
            .SHIFT  (SHIFT),
            .OUT_W  (OUT_W)
         ) u_scale (
            .bits_i (st[BITS_PER_CH-1:0]),
            .temp_i (temp_i),
            .val_o  (scaled)
         );

         always_ff @(posedge clk) begin
            if (rst)      noise_q <= '0;
            else if (adv) noise_q <= scaled;
         end

         assign noise_o[c*OUT_W +: OUT_W]     = noise_q;
         assign lfsr_flat[c*LFSR_W +: LFSR_W] = st;
      end
   endgenerate
endmodule

// File: rtl/bnoise_chk.sv
module bnoise_chk #(
   parameter int NUM_CH  = 32,
   parameter int OUT_W   = 8,
   parameter int LW      = 32,
   parameter int TEMP_W  = 4,
   parameter int MAX_MAG = 60
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    en_i,
   input logic                    seed_load_i,
   input logic [TEMP_W-1:0]       temp_i,
   input logic [NUM_CH*OUT_W-1:0] noise_o,
   input logic [NUM_CH*LW-1:0]    lfsr_flat
);
   // R5
   zero_temp_chk: assert property (@(posedge clk) disable iff (rst)
      (en_i && !seed_load_i && temp_i == '0) |=> (noise_o == '0));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!en_i && !seed_load_i) |=> $stable(noise_o));

   // R7
   load_hold_chk: assert property (@(posedge clk) disable iff (rst)
      seed_load_i |=> $stable(noise_o));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_c
         // R8
         lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
            lfsr_flat[c*LW +: LW] != '0);
         // R4
         mag_range_chk: assert property (@(posedge clk) disable iff (rst)
            ($signed(noise_o[c*OUT_W +: OUT_W]) <= MAX_MAG) &&
            ($signed(noise_o[c*OUT_W +: OUT_W]) >= -MAX_MAG - 1));
      end
   endgenerate
endmodule

bind bnoise_gen bnoise_chk #(
   .NUM_CH  (NUM_CH),
   .OUT_W   (OUT_W),
   .LW      (bnoise_pkg::LFSR_W),
   .TEMP_W  (TEMP_W),
   .MAX_MAG (MAX_MAG)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .en_i        (en_i),
   .seed_load_i (seed_load_i),
   .temp_i      (temp_i),
   .noise_o     (noise_o),
   .lfsr_flat   (lfsr_flat)
);

// File: tb/bnoise_gen_tb.sv
`timescale 1ns/1ps
module bnoise_gen_tb;
   localparam int NCH = 32;
   localparam int OW  = 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            en_i = 1'b0;
   logic            seed_load_i = 1'b0;
   logic [31:0]     seed_i = '0;
   logic [3:0]      temp_i = '0;
   logic [NCH*OW-1:0] noise_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   bnoise_gen u_dut (
      .clk(clk), .rst(rst), .en_i(en_i), .seed_load_i(seed_load_i),
      .seed_i(seed_i), .temp_i(temp_i), .noise_o(noise_o)
   );

   always #2.5 clk = ~clk;

   // behavioural reference
   bit [31:0] m_st [NCH];
   int        m_out[NCH];

   function automatic bit [31:0] mk_seed(bit [31:0] base, int c);
      bit [31:0] k = 32'h9E3779B9;
      bit [31:0] v = base ^ (k * 32'(c + 1));
      return (v == 0) ? 32'd1 : v;
   endfunction

   function automatic bit [31:0] adv16(bit [31:0] s);
      for (int k = 0; k < 16; k++) s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      return s;
   endfunction

   function automatic int dut_ch(int c);
      logic signed [OW-1:0] v;
      v = noise_o[c*OW +: OW];
      return int'(v);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int c = 0; c < NCH; c++) begin m_st[c] = mk_seed(32'h5EED1234, c); m_out[c] = 0; end
      end else if (seed_load_i) begin
         for (int c = 0; c < NCH; c++) m_st[c] = mk_seed(seed_i, c);
      end else if (en_i) begin
         for (int c = 0; c < NCH; c++) begin
            m_out[c] = (($countones(m_st[c][15:0]) - 8) * int'(temp_i)) >>> 1;
            m_st[c]  = adv16(m_st[c]);
         end
      end
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // R1 R3 R4 R7 R8: per-cycle model comparison of every channel
   always @(negedge clk) begin
      if (!done) begin
         int bad = -1;
         for (int c = NCH - 1; c >= 0; c--) if (dut_ch(c) != m_out[c]) bad = c;
         if (bad < 0) check(1'b1, "R4", "model", 0, 0);
         else check(1'b0, "R4", $sformatf("ch%0d vs model", bad), dut_ch(bad), m_out[bad]);
      end
   end

   real s, ss, sx0, sx1, sxy, sx0q, sx1q, nn;

   task automatic clr_stats();
      s = 0; ss = 0; sx0 = 0; sx1 = 0; sxy = 0; sx0q = 0; sx1q = 0; nn = 0;
   endtask

   task automatic run_stats(int cyc);
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         for (int c = 0; c < NCH; c++) begin
            real x = real'(dut_ch(c));
            s += x; ss += x * x;
         end
         sx0 += real'(dut_ch(0)); sx1 += real'(dut_ch(5));
         sxy += real'(dut_ch(0) * dut_ch(5));
         sx0q += real'(dut_ch(0) * dut_ch(0)); sx1q += real'(dut_ch(5) * dut_ch(5));
         nn += 1.0;
      end
   endtask

   initial begin
      real mean, var15, var4, var8, cov, corr, ratio;
      int  prev[NCH];
      repeat (4) @(negedge clk);
      // R2: reset state
      for (int c = 0; c < NCH; c++) check(dut_ch(c) == 0, "R2", $sformatf("reset ch%0d", c), dut_ch(c), 0);
      rst = 1'b0; en_i = 1'b1; temp_i = 4'd15;
      @(negedge clk);
      clr_stats();
      run_stats(3000);
      mean  = s / (nn * NCH);
      var15 = ss / (nn * NCH) - mean * mean;
      // R9: zero mean, variance ~ (15/2)^2 * 4
      check(mean > -0.5 && mean < 0.5, "R9", "mean*100 temp15", int'(mean * 100), 0);
      check(var15 > 190.0 && var15 < 260.0, "R9", "variance temp15", int'(var15), 225);
      // R10: correlation of channels 0 and 5
      cov  = sxy / nn - (sx0 / nn) * (sx1 / nn);
      corr = cov / $sqrt((sx0q / nn - (sx0 / nn) ** 2) * (sx1q / nn - (sx1 / nn) ** 2));
      check(corr > -0.06 && corr < 0.06, "R10", "corr*1000 ch0/ch5", int'(corr * 1000), 0);

      // R5: temperature zero
      temp_i = 4'd0;
      @(negedge clk);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check(noise_o == '0, "R5", "temp0 any channel nonzero", int'($countones(noise_o)), 0);
      end

      // R6: idle hold
      temp_i = 4'd9;
      @(negedge clk);
      en_i = 1'b0;
      @(negedge clk);
      for (int c = 0; c < NCH; c++) prev[c] = dut_ch(c);
      for (int i = 0; i < 15; i++) begin
         temp_i = 4'(i);
         @(negedge clk);
         check(dut_ch(3) == prev[3] && dut_ch(30) == prev[30], "R6", "idle ch3", dut_ch(3), prev[3]);
      end
      en_i = 1'b1; temp_i = 4'd11;
      repeat (50) @(negedge clk);

      // R7: load with en high, seed makes channel 2 derive to zero (R8 substitution)
      for (int c = 0; c < NCH; c++) prev[c] = dut_ch(c);
      seed_i = 32'h9E3779B9 * 32'd3; seed_load_i = 1'b1;
      @(negedge clk);
      for (int c = 0; c < NCH; c++) check(dut_ch(c) == prev[c], "R7", $sformatf("load hold ch%0d", c), dut_ch(c), prev[c]);
      seed_load_i = 1'b0;
      repeat (200) @(negedge clk);
      check(dut_ch(2) == m_out[2], "R8", "zero-seed channel alive", dut_ch(2), m_out[2]);
      seed_i = 32'h0; seed_load_i = 1'b1;
      @(negedge clk);
      seed_load_i = 1'b0;
      repeat (100) @(negedge clk);

      // R9: spread proportional to temperature
      temp_i = 4'd4; @(negedge clk);
      clr_stats(); run_stats(1500);
      var4 = ss / (nn * NCH) - (s / (nn * NCH)) ** 2;
      temp_i = 4'd8; @(negedge clk);
      clr_stats(); run_stats(1500);
      var8 = ss / (nn * NCH) - (s / (nn * NCH)) ** 2;
      ratio = $sqrt(var8 / var4);
      check(ratio > 1.8 && ratio < 2.2, "R9", "std ratio*100 temp8/temp4", int'(ratio * 100), 200);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule